// File: doc/BRIEF.md
# DMA Channel Setup Register File

This block is the programming front end of a four-channel DMA slice. A host issues byte writes to a small set of ports: a per-channel mask port, a mode port, a clear port for the shared byte pointer, and per-channel page, address and count ports. The 16-bit address and count values arrive as two byte writes, low then high. Which byte a write lands in is decided by a single byte-pointer flip-flop that all address and count ports share. The mask and mode ports take the channel number in the low two bits of the written byte. The other ports take it from the low two bits of the port select.

A transfer engine reads each channel's 24-bit address (page above a 16-bit offset), its 16-bit count, its mode bits and its mask. Raw requests are gated by the mask. Each acknowledged transfer on an unmasked channel moves the address up by one and the count down by one. The count is loaded as the number of transfers minus one. When an acknowledge arrives with the count at zero, the block pulses terminal count for one cycle. The channel then either masks itself or, with auto-initialize set, reloads the address and count it was last programmed with.

The host write and acknowledge inputs are plain strobes with no back-pressure. Every write and every acknowledge is taken in the cycle it is presented. A host write to a channel wins over an acknowledge to that same channel in the same cycle.

Top module: `dma_regfile`

## Requirements
- R1: While reset is asserted, and after it, every channel is masked, every address, count and mode reads zero, terminal count is low, and the byte pointer selects the low byte.
- R2: A write to the mask port (reg_sel = 0x0) with data bit 2 set masks the channel named in data bits [1:0]. The same write with bit 2 clear unmasks that channel. Other channels keep their mask.
- R3: A write of any value to the clear port (reg_sel = 0x2) sets the byte pointer to low, so the next address or count byte goes to bits [7:0]. The clear write changes no address or count.
- R4: Address ports are reg_sel = 0x4 + channel and count ports are reg_sel = 0x8 + channel. With the byte pointer low, a byte goes to bits [7:0]. With it high, the byte goes to bits [15:8]. Every address or count byte write flips the pointer, and that one pointer is shared by all channels and by both the address and count ports.
- R5: A write to the page port (reg_sel = 0xC + channel) sets bits [23:16] of that channel's address output. Offset stepping never carries into the page.
- R6: A write to the mode port (reg_sel = 0x1) selects the channel by data bits [1:0] and stores data bits [7:2] as that channel's 6-bit mode output. Data bit 4, which is mode output bit 2, is auto-initialize.
- R7: A channel's request output is high exactly when its raw request input is high and the channel is unmasked.
- R8: An acknowledge on an unmasked channel whose count is not zero adds one to the 16-bit address offset and subtracts one from the count. This takes effect in the next cycle.
- R9: An acknowledge on an unmasked channel whose count is zero pulses that channel's terminal count for one cycle and wraps the count to 0xFFFF. Without auto-initialize the channel becomes masked. A programmed count N therefore ends on the N+1th acknowledge.
- R10: With auto-initialize set, the terminal-count acknowledge reloads the last programmed address and count, and the channel stays unmasked.
- R11: An acknowledge on a masked channel changes no address, count or mask and gives no terminal count.
- R12: A write to the unused port code reg_sel = 0x3 changes no register and does not move the byte pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Host byte write strobe |
| reg_sel | input | 4 | Port select: [3:2] kind, [1:0] channel or control code |
| reg_wdata | input | 8 | Host write byte |
| dreq | input | NCH (4) | Raw transfer requests per channel |
| ack_valid | input | 1 | Transfer acknowledge strobe |
| ack_ch | input | 2 | Channel that the acknowledge belongs to |
| req_out | output | NCH (4) | Mask-gated requests to the arbiter |
| addr_out | output | NCH*24 (96) | Per-channel {page, offset}, channel i at [i*24 +: 24] |
| count_out | output | NCH*16 (64) | Per-channel remaining count, channel i at [i*16 +: 16] |
| mode_out | output | NCH*6 (24) | Per-channel mode bits, channel i at [i*6 +: 6] |
| mask_out | output | NCH (4) | Per-channel mask, 1 = masked |
| tc_out | output | NCH (4) | One-cycle terminal-count pulse per channel |

## Verification
The byte pointer is hidden, and a wrong pointer value shows up only on the next address or count write. That byte lands in the wrong half of the register and is visible on the outputs one cycle later. The stimulus therefore interleaves writes across channels, ports and clear writes, and reads back the halves. A fault in the decrement or terminal-count path can stay hidden for hundreds of acknowledges. It shows up as a count or address off by one, a terminal-count pulse one acknowledge early or late, or a mask bit that fails to set. So a full 512-transfer run is stepped to its end and checked both just before and at the wrap. An auto-initialize fault appears one cycle after the terminal acknowledge, as a stale address or count or a set mask bit.

// File: rtl/dma_regs_pkg.sv
package dma_regs_pkg;

  // Port kind carried in reg_sel[3:2]
  typedef enum logic [1:0] {
    KIND_CTRL  = 2'd0,
    KIND_ADDR  = 2'd1,
    KIND_COUNT = 2'd2,
    KIND_PAGE  = 2'd3
  } port_kind_e;

  // Control codes carried in reg_sel[1:0] when the kind is KIND_CTRL
  localparam logic [1:0] CTRL_MASK  = 2'd0;
  localparam logic [1:0] CTRL_MODE  = 2'd1;
  localparam logic [1:0] CTRL_CLEAR = 2'd2;

  // Field positions inside host bytes
  localparam int MASK_BIT      = 2;
  localparam int MODE_LSB      = 2;
  localparam int MODE_W        = 6;
  localparam int MODE_AUTO_BIT = 2;  // position inside the stored mode field

  // Per-channel load strobes from the decoder
  typedef struct packed {
    logic addr_lo;
    logic addr_hi;
    logic cnt_lo;
    logic cnt_hi;
    logic page;
    logic mode;
    logic mask_set;
    logic mask_clr;
  } chan_wr_t;

endpackage

// File: rtl/dma_port_decode.sv
module dma_port_decode
  import dma_regs_pkg::*;
#(
  parameter int NCH = 4,
  localparam int CHW = $clog2(NCH)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       we,
  input  logic [3:0] sel,
  input  logic [7:0] wdata,
  output chan_wr_t   wr [NCH]
);

  port_kind_e kind;
  logic [1:0] code;
  logic       byte_hi_q;
  logic       byte_access;
  logic       ptr_clear;

  assign kind = port_kind_e'(sel[3:2]);
  assign code = sel[1:0];

  // Any address or count byte moves the shared pointer
  assign byte_access = we && (kind == KIND_ADDR || kind == KIND_COUNT);
  assign ptr_clear   = we && (kind == KIND_CTRL) && (code == CTRL_CLEAR);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      byte_hi_q <= 1'b0;
    end else if (ptr_clear) begin
      byte_hi_q <= 1'b0;
    end else if (byte_access) begin
      byte_hi_q <= ~byte_hi_q;
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_dec
    logic port_hit;
    logic data_hit;
    assign port_hit = (code[CHW-1:0] == CHW'(c));
    assign data_hit = (wdata[CHW-1:0] == CHW'(c));

    always_comb begin
      wr[c] = '0;
      if (we) begin
        unique case (kind)
          KIND_ADDR: begin
            wr[c].addr_lo = port_hit && !byte_hi_q;
            wr[c].addr_hi = port_hit &&  byte_hi_q;
          end
          KIND_COUNT: begin
            wr[c].cnt_lo = port_hit && !byte_hi_q;
            wr[c].cnt_hi = port_hit &&  byte_hi_q;
          end
          KIND_PAGE: begin
            wr[c].page = port_hit;
          end
          KIND_CTRL: begin
            if (code == CTRL_MASK) begin
              wr[c].mask_set = data_hit &&  wdata[MASK_BIT];
              wr[c].mask_clr = data_hit && !wdata[MASK_BIT];
            end else if (code == CTRL_MODE) begin
              wr[c].mode = data_hit;
            end
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/dma_chan.sv
module dma_chan
  import dma_regs_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 16,
  parameter int PW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  chan_wr_t          wr,
  input  logic [7:0]        wdata,
  input  logic              ack,
  output logic [PW+AW-1:0]  addr,
  output logic [CW-1:0]     count,
  output logic [MODE_W-1:0] mode,
  output logic              masked,
  output logic              tc
);

  logic [AW-1:0]     base_addr_q, cur_addr_q, base_addr_n, cur_addr_n;
  logic [CW-1:0]     base_cnt_q,  cur_cnt_q,  base_cnt_n,  cur_cnt_n;
  logic [PW-1:0]     page_q;
  logic [MODE_W-1:0] mode_q;
  logic              mask_q, mask_n;
  logic              step, term, auto_init;

  assign auto_init = mode_q[MODE_AUTO_BIT];
  assign step      = ack && !mask_q;
  assign term      = step && (cur_cnt_q == '0);

  always_comb begin
    base_addr_n = base_addr_q;
    base_cnt_n  = base_cnt_q;
    cur_addr_n  = cur_addr_q;
    cur_cnt_n   = cur_cnt_q;
    mask_n      = mask_q;

    // Transfer stepping
    if (step) begin
      cur_addr_n = cur_addr_q + AW'(1);
      cur_cnt_n  = cur_cnt_q - CW'(1);
      if (term) begin
        if (auto_init) begin
          cur_addr_n = base_addr_q;
          cur_cnt_n  = base_cnt_q;
        end else begin
          mask_n = 1'b1;
        end
      end
    end

    // Host writes take priority; base and current are written together
    if (wr.addr_lo) base_addr_n[7:0]    = wdata;
    if (wr.addr_hi) base_addr_n[AW-1:8] = wdata[AW-9:0];
    if (wr.addr_lo || wr.addr_hi) cur_addr_n = base_addr_n;

    if (wr.cnt_lo) base_cnt_n[7:0]    = wdata;
    if (wr.cnt_hi) base_cnt_n[CW-1:8] = wdata[CW-9:0];
    if (wr.cnt_lo || wr.cnt_hi) cur_cnt_n = base_cnt_n;

    if (wr.mask_set) mask_n = 1'b1;
    if (wr.mask_clr) mask_n = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_addr_q <= '0;
      cur_addr_q  <= '0;
      base_cnt_q  <= '0;
      cur_cnt_q   <= '0;
      page_q      <= '0;
      mode_q      <= '0;
      mask_q      <= 1'b1;
      tc          <= 1'b0;
    end else begin
      base_addr_q <= base_addr_n;
      cur_addr_q  <= cur_addr_n;
      base_cnt_q  <= base_cnt_n;
      cur_cnt_q   <= cur_cnt_n;
      mask_q      <= mask_n;
      tc          <= term;
      if (wr.page) page_q <= wdata[PW-1:0];
      if (wr.mode) mode_q <= wdata[MODE_LSB +: MODE_W];
    end
  end

  assign addr   = {page_q, cur_addr_q};
  assign count  = cur_cnt_q;
  assign mode   = mode_q;
  assign masked = mask_q;

endmodule

// File: rtl/dma_regfile.sv
module dma_regfile
  import dma_regs_pkg::*;
#(
  parameter int NCH = 4,
  parameter int AW  = 16,
  parameter int CW  = 16,
  parameter int PW  = 8,
  localparam int CHW = $clog2(NCH),
  localparam int XW  = PW + AW
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  reg_we,
  input  logic [3:0]            reg_sel,
  input  logic [7:0]            reg_wdata,
  input  logic [NCH-1:0]        dreq,
  input  logic                  ack_valid,
  input  logic [CHW-1:0]        ack_ch,
  output logic [NCH-1:0]        req_out,
  output logic [NCH*XW-1:0]     addr_out,
  output logic [NCH*CW-1:0]     count_out,
  output logic [NCH*MODE_W-1:0] mode_out,
  output logic [NCH-1:0]        mask_out,
  output logic [NCH-1:0]        tc_out
);

  chan_wr_t wr [NCH];

  dma_port_decode #(.NCH(NCH)) u_decode (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (reg_we),
    .sel   (reg_sel),
    .wdata (reg_wdata),
    .wr    (wr)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    logic chan_ack;
    assign chan_ack = ack_valid && (ack_ch == CHW'(c));

    dma_chan #(.AW(AW), .CW(CW), .PW(PW)) u_chan (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr     (wr[c]),
      .wdata  (reg_wdata),
      .ack    (chan_ack),
      .addr   (addr_out[c*XW +: XW]),
      .count  (count_out[c*CW +: CW]),
      .mode   (mode_out[c*MODE_W +: MODE_W]),
      .masked (mask_out[c]),
      .tc     (tc_out[c])
    );
  end

  assign req_out = dreq & ~mask_out;

endmodule

// File: rtl/dma_regs_checker.sv
module dma_regs_checker
  import dma_regs_pkg::*;
#(
  parameter int NCH = 4,
  parameter int AW  = 16,
  parameter int CW  = 16,
  parameter int PW  = 8,
  localparam int CHW = $clog2(NCH),
  localparam int XW  = PW + AW
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  reg_we,
  input logic [3:0]            reg_sel,
  input logic [7:0]            reg_wdata,
  input logic [NCH-1:0]        dreq,
  input logic                  ack_valid,
  input logic [CHW-1:0]        ack_ch,
  input logic [NCH-1:0]        req_out,
  input logic [NCH*XW-1:0]     addr_out,
  input logic [NCH*CW-1:0]     count_out,
  input logic [NCH*MODE_W-1:0] mode_out,
  input logic [NCH-1:0]        mask_out,
  input logic [NCH-1:0]        tc_out
);

  for (genvar c = 0; c < NCH; c++) begin : g_chk
    logic hit_ack;
    assign hit_ack = ack_valid && (ack_ch == CHW'(c));

    // R2: a mask write with the mask bit set leaves the channel masked
    assert_mask_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && reg_sel == 4'h0 && reg_wdata[CHW-1:0] == CHW'(c) && reg_wdata[MASK_BIT])
      |=> mask_out[c]);

    // R8: unmasked, nonzero count: the count drops by one
    assert_count_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_ack && !mask_out[c] && !reg_we && count_out[c*CW +: CW] != '0)
      |=> count_out[c*CW +: CW] == $past(count_out[c*CW +: CW]) - CW'(1));

    // R9: terminal count without auto-initialize leaves the channel masked
    assert_tc_masks_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (tc_out[c] && !mode_out[c*MODE_W + MODE_AUTO_BIT] && !$past(reg_we))
      |-> mask_out[c]);

    // R10: terminal count with auto-initialize keeps the channel live
    assert_tc_autoinit_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (tc_out[c] && mode_out[c*MODE_W + MODE_AUTO_BIT] && !$past(reg_we))
      |-> !mask_out[c]);

    // R11: an acknowledge to a masked channel leaves the count alone
    assert_masked_ack_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_ack && mask_out[c] && !reg_we)
      |=> $stable(count_out[c*CW +: CW]) && !tc_out[c]);
  end

endmodule

bind dma_regfile dma_regs_checker #(.NCH(NCH), .AW(AW), .CW(CW), .PW(PW)) u_regs_checker (.*);

// File: tb/test_dma_regfile.sv
`timescale 1ns/1ps
module test_dma_regfile;

  localparam int NCH = 4;
  localparam int XW  = 24;
  localparam int CW  = 16;
  localparam int MW  = 6;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              reg_we = 1'b0;
  logic [3:0]        reg_sel = '0;
  logic [7:0]        reg_wdata = '0;
  logic [NCH-1:0]    dreq = '0;
  logic              ack_valid = 1'b0;
  logic [1:0]        ack_ch = '0;
  logic [NCH-1:0]    req_out;
  logic [NCH*XW-1:0] addr_out;
  logic [NCH*CW-1:0] count_out;
  logic [NCH*MW-1:0] mode_out;
  logic [NCH-1:0]    mask_out;
  logic [NCH-1:0]    tc_out;

  int n_vec  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  dma_regfile i_dma_regfile (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .dreq(dreq), .ack_valid(ack_valid), .ack_ch(ack_ch),
    .req_out(req_out), .addr_out(addr_out), .count_out(count_out),
    .mode_out(mode_out), .mask_out(mask_out), .tc_out(tc_out)
  );

  // what: 0 address, 1 count, 2 mask, 3 mode
  typedef struct packed {
    logic [3:0]  sel;
    logic [7:0]  data;
    logic [1:0]  what;
    logic [1:0]  ch;
    logic [23:0] exp;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VECS [NV] = '{
    '{4'h2, 8'h00, 2'd2, 2'd0, 24'h00000F},  // R3 clear, all still masked
    '{4'h5, 8'h34, 2'd0, 2'd1, 24'h000034},  // R4 addr ch1 low
    '{4'h5, 8'h12, 2'd0, 2'd1, 24'h001234},  // R4 addr ch1 high
    '{4'h9, 8'hFF, 2'd1, 2'd1, 24'h0000FF},  // R4 count ch1 low
    '{4'h9, 8'h01, 2'd1, 2'd1, 24'h0001FF},  // R4 count ch1 high = 511
    '{4'hD, 8'h05, 2'd0, 2'd1, 24'h051234},  // R5 page ch1
    '{4'h1, 8'h45, 2'd3, 2'd1, 24'h000011},  // R6 mode ch1, single, no auto
    '{4'h0, 8'h01, 2'd2, 2'd0, 24'h00000D},  // R2 unmask ch1
    '{4'h6, 8'hAA, 2'd0, 2'd2, 24'h0000AA},  // R4 addr ch2 low, pointer now high
    '{4'h2, 8'h5A, 2'd0, 2'd2, 24'h0000AA},  // R3 clear leaves data
    '{4'h6, 8'hBB, 2'd0, 2'd2, 24'h0000BB},  // R3 low byte again after clear
    '{4'hB, 8'h77, 2'd1, 2'd3, 24'h007700},  // R4 shared pointer: count ch3 high
    '{4'hB, 8'h66, 2'd1, 2'd3, 24'h007766},  // R4 then low
    '{4'h3, 8'hFF, 2'd2, 2'd0, 24'h00000D},  // R12 unused port, mask unchanged
    '{4'hB, 8'h11, 2'd1, 2'd3, 24'h001166},  // R12 pointer not moved: still high
    '{4'h0, 8'h05, 2'd2, 2'd0, 24'h00000F},  // R2 mask ch1
    '{4'h0, 8'h01, 2'd2, 2'd0, 24'h00000D}   // R2 unmask ch1 again
  };

  function automatic logic [23:0] observe(input logic [1:0] what, input int ch);
    case (what)
      2'd0:    return addr_out[ch*XW +: XW];
      2'd1:    return {8'h00, count_out[ch*CW +: CW]};
      2'd2:    return {20'h0, mask_out};
      default: return {18'h0, mode_out[ch*MW +: MW]};
    endcase
  endfunction

  task automatic check(input string req, input logic [23:0] act, input logic [23:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %06h expected %06h", req, act, exp);
    end
  endtask

  task automatic host_write(input logic [3:0] sel, input logic [7:0] data);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = sel; reg_wdata = data;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic do_ack(input logic [1:0] ch);
    @(negedge clk);
    ack_valid = 1'b1; ack_ch = ch;
    @(negedge clk);
    ack_valid = 1'b0;
  endtask

  task automatic finish_run;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected completion");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state while reset is held
    check("R1", {20'h0, mask_out}, 24'h00000F);
    check("R1", {20'h0, tc_out}, 24'h0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int c = 0; c < NCH; c++) begin
      check("R1", observe(2'd0, c), 24'h0);
      check("R1", observe(2'd1, c), 24'h0);
      check("R1", observe(2'd3, c), 24'h0);
    end

    // Table walk
    for (int i = 0; i < NV; i++) begin
      host_write(VECS[i].sel, VECS[i].data);
      check($sformatf("table %0d (R2-R6,R12)", i), observe(VECS[i].what, VECS[i].ch), VECS[i].exp);
    end

    // R7: request gating, mask is 1101
    dreq = 4'hF;
    #1 check("R7", {20'h0, req_out}, 24'h000002);
    dreq = 4'h0;

    // R8: 511 acknowledges on ch1 step without terminal count
    for (int k = 0; k < 511; k++) begin
      do_ack(2'd1);
      if (tc_out != 4'h0) check("R8 early tc", {20'h0, tc_out}, 24'h0);
    end
    check("R8", observe(2'd1, 1), 24'h000000);
    check("R8", observe(2'd0, 1), 24'h051433);
    check("R8", {20'h0, mask_out}, 24'h00000D);
    // R9: 512th acknowledge hits terminal count
    do_ack(2'd1);
    check("R9 tc", {20'h0, tc_out}, 24'h000002);
    check("R9 wrap", observe(2'd1, 1), 24'h00FFFF);
    check("R9 mask", {20'h0, mask_out}, 24'h00000F);
    check("R9 addr", observe(2'd0, 1), 24'h051434);
    @(negedge clk);
    check("R9 pulse", {20'h0, tc_out}, 24'h0);

    // R11: acknowledges on masked channels have no effect
    do_ack(2'd1);
    check("R11", observe(2'd1, 1), 24'h00FFFF);
    check("R11", observe(2'd0, 1), 24'h051434);
    check("R11", {20'h0, tc_out}, 24'h0);
    do_ack(2'd0);
    check("R11", observe(2'd1, 0), 24'h0);
    check("R11", {20'h0, mask_out}, 24'h00000F);

    // R10: auto-initialize on ch3
    host_write(4'h2, 8'h00);
    host_write(4'hB, 8'h02);
    host_write(4'hB, 8'h00);
    host_write(4'h7, 8'h10);
    host_write(4'h7, 8'h00);
    host_write(4'h1, 8'h53);
    host_write(4'h0, 8'h03);
    check("R10 setup", observe(2'd3, 3), 24'h000014);
    do_ack(2'd3);
    do_ack(2'd3);
    check("R10 step", observe(2'd0, 3), 24'h000012);
    check("R10 step", observe(2'd1, 3), 24'h000000);
    do_ack(2'd3);
    check("R10 tc", {20'h0, tc_out}, 24'h000008);
    check("R10 addr", observe(2'd0, 3), 24'h000010);
    check("R10 count", observe(2'd1, 3), 24'h000002);
    check("R10 mask", {20'h0, mask_out}, 24'h000007);

    // R1: reset again mid-run
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    check("R1 rerun", {20'h0, mask_out}, 24'h00000F);
    check("R1 rerun", observe(2'd1, 3), 24'h0);
    // R1: pointer back to low after reset
    host_write(4'h4, 8'h9C);
    check("R1 pointer", observe(2'd0, 0), 24'h00009C);

    done = 1'b1;
    finish_run();
  end

endmodule